// File: doc/BRIEF.md
# Class-Dependent Exception Priority Resolver

This block sits at the issue stage of a simple in-order processor. For the instruction being issued it takes one pending flag per exception source and chooses the single exception to take. The ranking of the sources depends on the class of the instruction: branch, return-from-interrupt, preserved or reserved. Inside the preserved class the ranking also depends on whether the instruction is the time-base read, which is the only preserved-class instruction the processor implements.

A debug enable input masks every debug-event source. A masked source lets the next eligible source win. The choice is registered. It appears one clock after the inputs as a valid bit, a one-hot vector and a 3-bit cause code. Each result is held for one cycle only and is replaced by the result for the inputs sampled at the next edge. Detecting the raw conditions, generating vectors and saving or restoring interrupt state are handled by the surrounding logic.

Top module: `exc_prio_resolver`

## Requirements
- R1: For every class, the top three priorities, highest first, are the address-compare debug event (pend bit 0), the instruction TLB miss (bit 1) and the execute-access-control storage violation (bit 2).
- R2: For class code 0 (branch), the fourth priority is the branch-taken debug event (bit 3) and the fifth is the completion debug event (bit 6).
- R3: For class code 1 (any return-from-interrupt variant), the fourth priority is the return debug event (bit 4) and the fifth is the completion debug event (bit 6).
- R4: For class code 2 (preserved) with tb_read low, the fourth priority is the illegal-instruction exception (bit 5), and the completion debug event is never chosen.
- R5: For class code 2 with tb_read high, the fourth eligible priority is the completion debug event (bit 6), and the illegal-instruction exception is never chosen.
- R6: For class code 3 (reserved), the illegal-instruction exception is the fourth and last priority. The branch-taken, return and completion debug events are ignored.
- R7: A pending flag that does not apply to the current class, or to the current preserved-class instruction, is never chosen, even when it is the only flag asserted.
- R8: When dbg_en is low, the debug sources (bits 0, 3, 4 and 6) are masked, and the next eligible pending source is chosen instead.
- R9: The cause code is 0 for none, 1 for address compare, 2 for TLB miss, 3 for storage violation, 4 for branch-taken debug, 5 for return debug, 6 for illegal instruction and 7 for completion debug. One-hot bit i corresponds to cause i+1.
- R10: When no eligible source is pending, sel_vld is 0, sel_vec is all zeros and sel_cause is 0.
- R11: Outputs change one clock after the inputs are sampled. A synchronous active-high rst clears all outputs.
- R12: sel_vec has at most one bit set, and that bit always matches sel_cause in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_class | input | 2 | Instruction class: 0 branch, 1 return-from-interrupt, 2 preserved, 3 reserved |
| tb_read | input | 1 | High when the preserved-class instruction is the time-base read |
| dbg_en | input | 1 | Enables all debug-event sources |
| pend | input | 7 | Pending flags, one per source, with the bit order given in R1 to R6 |
| sel_vld | output | 1 | Registered: an exception was chosen |
| sel_vec | output | 7 | Registered one-hot selection |
| sel_cause | output | 3 | Registered cause code (R9) |

## Verification
The hardest cases to reach are the ones where the only asserted flags are ineligible for the class or instruction, or are debug sources while debug is disabled. Uniform random pending vectors almost always include an eligible top-three source, and that hides these cases. The stimulus therefore draws the top three flags with a low probability. It also adds directed cases in which only one inapplicable flag is set for each class and each tb_read value. It then sweeps dbg_en with only debug sources plus one lower source pending.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

    localparam int unsigned N_SRC   = 7;
    localparam int unsigned CAUSE_W = $clog2(N_SRC + 1);

    localparam int unsigned S_IAC = 0;
    localparam int unsigned S_TLB = 1;
    localparam int unsigned S_XAC = 2;
    localparam int unsigned S_BRT = 3;
    localparam int unsigned S_RET = 4;
    localparam int unsigned S_ILL = 5;
    localparam int unsigned S_CMP = 6;

    typedef enum logic [1:0] {
        CLS_BRANCH = 2'd0,
        CLS_RFI    = 2'd1,
        CLS_PRESV  = 2'd2,
        CLS_RSVD   = 2'd3
    } ins_class_e;

    typedef logic [N_SRC-1:0]   src_vec_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef struct packed {
        logic     vld;
        src_vec_t vec;
        cause_t   cause;
    } sel_t;

    localparam src_vec_t DBG_SRCS = src_vec_t'((1 << S_IAC) | (1 << S_BRT) | (1 << S_RET) | (1 << S_CMP));
    localparam src_vec_t TOP3     = src_vec_t'((1 << S_IAC) | (1 << S_TLB) | (1 << S_XAC));

    // Sources applicable to a class; the index order equals rank order in every class.
    function automatic src_vec_t class_applicable(ins_class_e cls, logic is_tb);
        src_vec_t m;
        m = TOP3;
        case (cls)
            CLS_BRANCH: m = m | src_vec_t'((1 << S_BRT) | (1 << S_CMP));
            CLS_RFI:    m = m | src_vec_t'((1 << S_RET) | (1 << S_CMP));
            CLS_PRESV:  m = m | (is_tb ? src_vec_t'(1 << S_CMP) : src_vec_t'(1 << S_ILL));
            default:    m = m | src_vec_t'(1 << S_ILL);
        endcase
        return m;
    endfunction

    function automatic cause_t onehot_to_cause(src_vec_t v);
        cause_t c;
        c = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (v[i]) c = c | cause_t'(i + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/exc_elig_mask.sv
module exc_elig_mask
    import exc_prio_pkg::*;
(
    input  ins_class_e cls,
    input  logic       is_tb,
    input  logic       dbg_en,
    input  src_vec_t   pend,
    output src_vec_t   elig
);
    src_vec_t appl;
    src_vec_t dbg_gate;

    always_comb begin
        appl     = class_applicable(cls, is_tb);
        dbg_gate = dbg_en ? '1 : ~DBG_SRCS;
        elig     = pend & appl & dbg_gate;
    end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int unsigned N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] blk;

    assign blk[0] = 1'b0;

    genvar i;
    generate
        for (i = 1; i < N; i++) begin : g_chain
            assign blk[i] = blk[i-1] | req[i-1];
        end
        for (i = 0; i < N; i++) begin : g_grant
            assign grant[i] = req[i] & ~blk[i];
        end
    endgenerate
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
    import exc_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         ins_class,
    input  logic               tb_read,
    input  logic               dbg_en,
    input  logic [N_SRC-1:0]   pend,
    output logic               sel_vld,
    output logic [N_SRC-1:0]   sel_vec,
    output logic [CAUSE_W-1:0] sel_cause
);
    ins_class_e cls;
    src_vec_t   elig;
    src_vec_t   grant;
    sel_t       nxt;
    sel_t       q;

    assign cls = ins_class_e'(ins_class);

    exc_elig_mask u_mask (
        .cls    (cls),
        .is_tb  (tb_read),
        .dbg_en (dbg_en),
        .pend   (pend),
        .elig   (elig)
    );

    exc_prio_pick #(.N(N_SRC)) u_pick (
        .req   (elig),
        .grant (grant)
    );

    always_comb begin
        nxt.vld   = |grant;
        nxt.vec   = grant;
        nxt.cause = onehot_to_cause(grant);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign sel_vld   = q.vld;
    assign sel_vec   = q.vec;
    assign sel_cause = q.cause;

    // R12: one-hot and consistent with cause
    p_onehot_r12: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_vec));
    p_cause_match_r12: assert property (@(posedge clk) disable iff (rst)
        sel_vld |-> (sel_cause != '0) && (sel_vec == src_vec_t'(1 << (sel_cause - 1'b1))));
    // R10: nothing valid means everything clear
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !sel_vld |-> (sel_vec == '0) && (sel_cause == '0));
    // R8: debug disabled, no debug cause next cycle
    p_dbg_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !dbg_en |=> !(sel_vec[S_IAC] | sel_vec[S_BRT] | sel_vec[S_RET] | sel_vec[S_CMP]));
    // R7: class-inapplicable sources never chosen
    p_brt_branch_only_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_class != 2'd0) |=> !sel_vec[S_BRT]);
    p_ret_rfi_only_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_class != 2'd1) |=> !sel_vec[S_RET]);
    // R1: TLB miss wins when address compare is not eligible
    p_tlb_rank_r1: assert property (@(posedge clk) disable iff (rst)
        (pend[S_TLB] && !(dbg_en && pend[S_IAC])) |=> sel_vec[S_TLB]);
    // R5: time-base read never yields illegal instruction
    p_tb_no_ill_r5: assert property (@(posedge clk) disable iff (rst)
        (ins_class == 2'd2 && tb_read) |=> !sel_vec[S_ILL]);
endmodule

// File: tb/sim_exc_prio_resolver.sv
module sim_exc_prio_resolver;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ins_class;
    logic       tb_read;
    logic       dbg_en;
    logic [6:0] pend;
    logic       sel_vld;
    logic [6:0] sel_vec;
    logic [2:0] sel_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(PER/2) clk = ~clk;

    exc_prio_resolver u0 (
        .clk(clk), .rst(rst), .ins_class(ins_class), .tb_read(tb_read),
        .dbg_en(dbg_en), .pend(pend),
        .sel_vld(sel_vld), .sel_vec(sel_vec), .sel_cause(sel_cause)
    );

    // Expected cause from the ranked lists in the requirements.
    function automatic int exp_cause(logic [1:0] c, logic t, logic d, logic [6:0] p);
        int ord[5];
        int n;
        ord[0] = 0; ord[1] = 1; ord[2] = 2;
        case (c)
            2'd0: begin ord[3] = 3; ord[4] = 6; n = 5; end
            2'd1: begin ord[3] = 4; ord[4] = 6; n = 5; end
            2'd2: begin ord[3] = t ? 6 : 5; ord[4] = 0; n = 4; end
            default: begin ord[3] = 5; ord[4] = 0; n = 4; end
        endcase
        for (int k = 0; k < n; k++) begin
            int s;
            bit is_dbg;
            s = ord[k];
            is_dbg = (s == 0) || (s == 3) || (s == 4) || (s == 6);
            if (p[s] && (d || !is_dbg)) return s + 1;
        end
        return 0;
    endfunction

    task automatic check_out(string req, int ec);
        logic [6:0] ev;
        ev = (ec == 0) ? 7'd0 : 7'(1 << (ec - 1));
        total++;
        if (sel_cause !== 3'(ec) || sel_vec !== ev || sel_vld !== (ec != 0)) begin
            bad++;
            $display("FAIL %s: got vld=%0b vec=%b cause=%0d, expected vld=%0b vec=%b cause=%0d",
                     req, sel_vld, sel_vec, sel_cause, (ec != 0), ev, ec);
        end
    endtask

    task automatic apply(string req, logic [1:0] c, logic t, logic d, logic [6:0] p);
        @(negedge clk);
        ins_class = c; tb_read = t; dbg_en = d; pend = p;
        @(posedge clk);
        #1;
        check_out(req, exp_cause(c, t, d, p));
    endtask

    // Same as apply, but the expected cause is written out by hand.
    task automatic apply_fixed(string req, logic [1:0] c, logic t, logic d, logic [6:0] p, int ec);
        @(negedge clk);
        ins_class = c; tb_read = t; dbg_en = d; pend = p;
        @(posedge clk);
        #1;
        check_out(req, ec);
    endtask

    initial begin
        void'($urandom(32'd4401));
        rst = 1'b1; ins_class = 2'd0; tb_read = 1'b0; dbg_en = 1'b1; pend = 7'h7f;
        repeat (3) @(posedge clk);
        #1;
        check_out("R11 reset", 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_out("R11 first sample", 1);

        // R1 top three, every class
        for (int c = 0; c < 4; c++) begin
            apply_fixed("R1 iac", 2'(c), 1'b0, 1'b1, 7'h7f, 1);
            apply_fixed("R1 tlb", 2'(c), 1'b0, 1'b1, 7'h7e, 2);
            apply_fixed("R1 xac", 2'(c), 1'b1, 1'b1, 7'h7c, 3);
        end
        apply_fixed("R2 brt", 2'd0, 1'b0, 1'b1, 7'h78, 4);
        apply_fixed("R2 cmp", 2'd0, 1'b0, 1'b1, 7'h70, 7);
        apply_fixed("R3 ret", 2'd1, 1'b0, 1'b1, 7'h78, 5);
        apply_fixed("R3 cmp", 2'd1, 1'b0, 1'b1, 7'h68, 7);
        apply_fixed("R4 ill", 2'd2, 1'b0, 1'b1, 7'h78, 6);
        apply_fixed("R4 no cmp", 2'd2, 1'b0, 1'b1, 7'h40, 0);
        apply_fixed("R5 cmp", 2'd2, 1'b1, 1'b1, 7'h78, 7);
        apply_fixed("R5 no ill", 2'd2, 1'b1, 1'b1, 7'h20, 0);
        apply_fixed("R6 ill", 2'd3, 1'b0, 1'b1, 7'h78, 6);
        apply_fixed("R6 ignored dbg", 2'd3, 1'b1, 1'b1, 7'h58, 0);
        // R7 single inapplicable flag
        apply_fixed("R7 ret on branch", 2'd0, 1'b0, 1'b1, 7'h10, 0);
        apply_fixed("R7 ill on branch", 2'd0, 1'b0, 1'b1, 7'h20, 0);
        apply_fixed("R7 brt on rfi", 2'd1, 1'b0, 1'b1, 7'h08, 0);
        apply_fixed("R7 brt on presv", 2'd2, 1'b1, 1'b1, 7'h08, 0);
        apply_fixed("R7 cmp on rsvd", 2'd3, 1'b0, 1'b1, 7'h40, 0);
        // R8 masking
        apply_fixed("R8 iac masked", 2'd0, 1'b0, 1'b0, 7'h49, 0);
        apply_fixed("R8 pass to tlb", 2'd1, 1'b0, 1'b0, 7'h53, 2);
        apply_fixed("R8 pass to ill", 2'd2, 1'b0, 1'b0, 7'h21, 6);
        apply_fixed("R8 tb cmp masked", 2'd2, 1'b1, 1'b0, 7'h40, 0);
        // R9 every cause code once
        apply_fixed("R9 code4", 2'd0, 1'b0, 1'b1, 7'h08, 4);
        apply_fixed("R9 code5", 2'd1, 1'b0, 1'b1, 7'h10, 5);
        apply_fixed("R9 code6", 2'd3, 1'b0, 1'b1, 7'h20, 6);
        apply_fixed("R9 code7", 2'd0, 1'b0, 1'b1, 7'h40, 7);
        apply_fixed("R10 none", 2'd1, 1'b0, 1'b1, 7'h00, 0);

        // Random traffic, top-three flags rare so low slots get exercised
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] c;
            logic [6:0] p;
            c = 2'($urandom_range(0, 3));
            p = 7'($urandom);
            if ($urandom_range(0, 3) != 0) p[2:0] = 3'b000;
            case (c)
                2'd0: apply("R2 R12 random branch", c, 1'($urandom), 1'($urandom), p);
                2'd1: apply("R3 R12 random rfi", c, 1'($urandom), 1'($urandom), p);
                2'd2: apply("R4 R5 random presv", c, 1'($urandom), 1'($urandom), p);
                default: apply("R6 random rsvd", c, 1'($urandom), 1'($urandom), p);
            endcase
        end

        // R11 reset mid-stream clears
        @(negedge clk);
        rst = 1'b1; pend = 7'h7f;
        @(posedge clk);
        #1;
        check_out("R11 reset mid", 0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule